// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO Controller

This block moves data words from a write clock domain to an unrelated read clock domain through an inferred storage array. Writes and reads are requested with active-low enables. Each side only sees the other side's pointer after that pointer has passed through a two-flop synchronizer as Gray code. The flags can therefore be late, but they are never early.

A mode pin is sampled while the asynchronous master reset is held. The chosen mode stays in force until the next reset.

- **Standard mode.** Every word must be requested with a read enable. The read status pin acts as an active-low empty flag, and the write status pin acts as an active-low full flag.
- **Fall-through mode.** An output register holds the head word, which appears without any request. Total capacity becomes the array depth plus one. The read status pin signals "no valid data" when high, and the write status pin signals "no room" when high.

Top module: `dmf_fifo`

## Requirements
- R1: While and after master reset, `rd_data` is 0. In standard mode `rd_status` is 0 and `wr_status` is 1. In fall-through mode `rd_status` is 1 and `wr_status` is 0.
- R2: `mode_sel` is sampled only while reset is held (0 = standard, 1 = fall-through). Changing it after reset has no effect on behaviour.
- R3: In standard mode, each low `rd_en_n` on a `rd_clk` edge with data present loads the oldest word into `rd_data` at that edge. Words leave in write order.
- R4: In standard mode, after a write into an empty FIFO, `rd_status` rises on the second `rd_clk` rising edge after the write edge. It falls once the last word is read.
- R5: In standard mode, `wr_status` goes low after DEPTH unread writes. A write attempted while full stores nothing.
- R6: In fall-through mode, the first word written into an empty FIFO is on `rd_data` with `rd_status` low from the third `rd_clk` rising edge after the write edge, with no read request.
- R7: In fall-through mode the FIFO holds DEPTH+1 words, and `wr_status` goes high only when all of them are stored. A write while full is dropped. After the first read from full, `wr_status` returns low.
- R8: A read request while the FIFO is empty leaves `rd_data`, the flags and the read pointer unchanged.
- R9: In fall-through mode the head word stays on `rd_data` for as long as `rd_en_n` is high. A low `rd_en_n` replaces it with the next word, or raises `rd_status` if no next word exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| mode_sel | input | 1 | Mode choice sampled during reset |
| wr_en_n | input | 1 | Write request, active low |
| wr_data | input | DATA_W | Word to store |
| wr_status | output | 1 | Full indication (polarity depends on mode) |
| rd_en_n | input | 1 | Read request, active low |
| rd_data | output | DATA_W | Registered output word |
| rd_status | output | 1 | Empty / not-ready indication (polarity depends on mode) |

## Verification
In fall-through mode a read request can land on the same read-clock edge that drains the output register and reloads it with the next stored word. The bench provokes this by popping a queue that holds many words, one request after another. It judges the result by requiring the following word on `rd_data` immediately after each pop, with no bubble and no skipped word.

The second overlap is a write that meets the full condition on the same edge at which a read frees a slot. The bench fills the FIFO to capacity, offers an extra word, and then pops once. It checks that the extra word never comes out and that the full indication clears only after the freed slot is seen through the synchronizer.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

  typedef enum logic {
    FIFO_STD  = 1'b0,
    FIFO_FALL = 1'b1
  } fifo_mode_e;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dmf_sync.sv
module dmf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/dmf_mem.sv
module dmf_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dmf_wr_ctrl.sv
module dmf_wr_ctrl
  import dmf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              wr_en_n,
  input  logic [ADDR_W:0]   rq_gray,
  output logic [ADDR_W:0]   wr_gray,
  output logic [ADDR_W-1:0] waddr,
  output logic              we,
  output logic              wr_status
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

  fifo_mode_e      mode_q;
  logic [PW-1:0]   wr_bin_q, wr_bin_d;
  logic [PW-1:0]   wr_gray_q, wr_gray_d;
  logic [PW-1:0]   rq_bin;
  logic [31:0]     rq_wide;
  logic            full;

  // mode captured only while the local reset is asserted
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= fifo_mode_e'(mode_sel);
    end
  end

  assign rq_wide = from_gray(32'(rq_gray));
  assign rq_bin  = rq_wide[PW-1:0];
  assign full    = (wr_bin_q - rq_bin) == DEPTH_P;
  assign we      = !wr_en_n && !full;

  always_comb begin
    wr_bin_d  = wr_bin_q;
    if (we) begin
      wr_bin_d = wr_bin_q + 1'b1;
    end
    wr_gray_d = PW'(to_gray(32'(wr_bin_d)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin_q  <= '0;
      wr_gray_q <= '0;
    end else begin
      wr_bin_q  <= wr_bin_d;
      wr_gray_q <= wr_gray_d;
    end
  end

  assign wr_gray   = wr_gray_q;
  assign waddr     = wr_bin_q[ADDR_W-1:0];
  assign wr_status = (mode_q == FIFO_FALL) ? full : !full;

  // R5 / R7: pointer frozen while full
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(full) |-> (wr_bin_q == $past(wr_bin_q)))
    else $error("write pointer moved while full");

  // R7: never more than DEPTH words ahead of the synchronized read pointer
  p_room_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bin_q - rq_bin) <= DEPTH_P)
    else $error("write side occupancy beyond depth");
endmodule

// File: rtl/dmf_rd_ctrl.sv
module dmf_rd_ctrl
  import dmf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              rd_en_n,
  input  logic [ADDR_W:0]   wq_gray,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W:0]   rd_gray,
  output logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_status
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

  fifo_mode_e        mode_q;
  logic [PW-1:0]     rd_bin_q, rd_bin_d;
  logic [PW-1:0]     rd_gray_q, rd_gray_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              ov_q, ov_d;
  logic [PW-1:0]     wq_bin;
  logic [31:0]       wq_wide;
  logic              empty, fall, std_rd, pop, load, take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= fifo_mode_e'(mode_sel);
    end
  end

  assign fall    = (mode_q == FIFO_FALL);
  assign wq_wide = from_gray(32'(wq_gray));
  assign wq_bin  = wq_wide[PW-1:0];
  assign empty   = (rd_bin_q == wq_bin);
  assign std_rd  = !fall && !rd_en_n && !empty;
  assign pop     = fall && ov_q && !rd_en_n;
  assign load    = fall && !empty && (!ov_q || pop);
  assign take    = std_rd || load;

  always_comb begin
    rd_bin_d = rd_bin_q;
    dout_d   = dout_q;
    ov_d     = ov_q;
    if (take) begin
      rd_bin_d = rd_bin_q + 1'b1;
      dout_d   = mem_rdata;
    end
    if (!fall) begin
      ov_d = 1'b0;
    end else if (load) begin
      ov_d = 1'b1;
    end else if (pop) begin
      ov_d = 1'b0;
    end
    rd_gray_d = PW'(to_gray(32'(rd_bin_d)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin_q  <= '0;
      rd_gray_q <= '0;
      dout_q    <= '0;
      ov_q      <= 1'b0;
    end else begin
      rd_bin_q  <= rd_bin_d;
      rd_gray_q <= rd_gray_d;
      dout_q    <= dout_d;
      ov_q      <= ov_d;
    end
  end

  assign rd_gray   = rd_gray_q;
  assign raddr     = rd_bin_q[ADDR_W-1:0];
  assign rd_data   = dout_q;
  assign rd_status = fall ? !ov_q : !empty;

  // R8: no pointer motion while storage is empty
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(empty) |-> (rd_bin_q == $past(rd_bin_q)))
    else $error("read pointer moved while empty");

  // R9: held head word stays put without a request
  p_head_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && ov_q && rd_en_n) |=> (ov_q && $stable(dout_q)))
    else $error("head word changed without a read");

  // R7: stored words never exceed array depth
  p_store_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wq_bin - rd_bin_q) <= DEPTH_P)
    else $error("read side occupancy beyond depth");
endmodule

// File: rtl/dmf_fifo.sv
module dmf_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_status,
  input  logic              rd_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_status
);
  localparam int PW = ADDR_W + 1;

  logic              wrst_n, rrst_n;
  logic [PW-1:0]     wr_gray, rd_gray, wq_gray, rq_gray;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              we;
  logic [DATA_W-1:0] mem_rdata;

  dmf_sync #(.W(1)) u_wrst (.clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wrst_n));
  dmf_sync #(.W(1)) u_rrst (.clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rrst_n));

  dmf_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rrst_n), .d(wr_gray), .q(wq_gray));
  dmf_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(wrst_n), .d(rd_gray), .q(rq_gray));

  dmf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata)
  );

  dmf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wr_clk), .rst_n(wrst_n), .mode_sel(mode_sel), .wr_en_n(wr_en_n),
    .rq_gray(rq_gray), .wr_gray(wr_gray), .waddr(waddr), .we(we),
    .wr_status(wr_status)
  );

  dmf_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst_n(rrst_n), .mode_sel(mode_sel), .rd_en_n(rd_en_n),
    .wq_gray(wq_gray), .mem_rdata(mem_rdata), .rd_gray(rd_gray),
    .raddr(raddr), .rd_data(rd_data), .rd_status(rd_status)
  );
endmodule

// File: tb/dmf_fifo_bench.sv
module dmf_fifo_bench;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0;
  logic wr_en_n = 1'b1;
  logic rd_en_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_status, rd_status;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 wr_clk = ~wr_clk;
  initial begin
    #5;
    forever #10 rd_clk = ~rd_clk;
  end

  dmf_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_dmf_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .wr_status(wr_status),
    .rd_en_n(rd_en_n), .rd_data(rd_data), .rd_status(rd_status)
  );

  // op bit 16 (1 = read), [15:8] write data, [7:0] expected read data
  localparam logic [16:0] VEC [12] = '{
    {1'b0, 8'h11, 8'h00}, {1'b0, 8'h22, 8'h00}, {1'b0, 8'h33, 8'h00},
    {1'b1, 8'h00, 8'h11}, {1'b0, 8'h44, 8'h00}, {1'b1, 8'h00, 8'h22},
    {1'b1, 8'h00, 8'h33}, {1'b0, 8'h55, 8'h00}, {1'b1, 8'h00, 8'h44},
    {1'b1, 8'h00, 8'h55}, {1'b0, 8'h66, 8'h00}, {1'b1, 8'h00, 8'h66}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    @(negedge wr_clk);
    rst_n = 1'b0;
    mode_sel = m;
    repeat (4) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (5) @(negedge rd_clk);
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en_n = 1'b0;
    wr_data = d;
    @(posedge wr_clk);
    #1 wr_en_n = 1'b1;
  endtask

  task automatic do_read();
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    @(posedge rd_clk);
    #1 rd_en_n = 1'b1;
    #2;
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;

    // ---------- standard mode ----------
    do_reset(1'b0);
    chk("R1 std rd_status", 32'(rd_status), 32'd0);
    chk("R1 std wr_status", 32'(wr_status), 32'd1);
    chk("R1 std rd_data", 32'(rd_data), 32'd0);

    // R3 vector walk
    foreach (VEC[i]) begin
      if (VEC[i][16]) begin
        do_read();
        chk("R3 ordered read", 32'(rd_data), 32'(VEC[i][7:0]));
      end else begin
        do_write(VEC[i][15:8]);
        repeat (4) @(negedge rd_clk);
      end
    end
    chk("R4 empty after drain", 32'(rd_status), 32'd0);

    // R8 read on empty ignored
    held = rd_data;
    do_read();
    chk("R8 data kept on empty read", 32'(rd_data), 32'(held));
    chk("R8 still empty", 32'(rd_status), 32'd0);
    do_write(8'h77);
    settle();
    do_read();
    chk("R8 pointer unmoved", 32'(rd_data), 32'h77);

    // R4 exact edge of empty release
    settle();
    @(negedge wr_clk);
    wr_en_n = 1'b0;
    wr_data = 8'h88;
    @(posedge wr_clk);
    #1 wr_en_n = 1'b1;
    @(posedge rd_clk);
    #2 chk("R4 still empty after one rd edge", 32'(rd_status), 32'd0);
    @(posedge rd_clk);
    #2 chk("R4 not empty after two rd edges", 32'(rd_status), 32'd1);
    do_read();
    chk("R4 read word", 32'(rd_data), 32'h88);

    // R5 fill, overflow attempt, drain
    settle();
    for (int i = 0; i < DEPTH; i++) do_write(DW'(8'h20 + i));
    settle();
    chk("R5 full flag low", 32'(wr_status), 32'd0);
    do_write(8'hEE);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      do_read();
      chk("R5 stored word", 32'(rd_data), 32'(8'h20 + i));
    end
    settle();
    chk("R5 overflow word dropped", 32'(rd_status), 32'd0);
    chk("R5 full released", 32'(wr_status), 32'd1);

    // ---------- fall-through mode ----------
    do_reset(1'b1);
    chk("R1 fall rd_status", 32'(rd_status), 32'd1);
    chk("R1 fall wr_status", 32'(wr_status), 32'd0);
    chk("R1 fall rd_data", 32'(rd_data), 32'd0);
    mode_sel = 1'b0; // R2: must be ignored now

    @(negedge wr_clk);
    wr_en_n = 1'b0;
    wr_data = 8'h40;
    @(posedge wr_clk);
    #1 wr_en_n = 1'b1;
    @(posedge rd_clk);
    @(posedge rd_clk);
    #2 chk("R6 not ready after two edges", 32'(rd_status), 32'd1);
    @(posedge rd_clk);
    #2 chk("R6 ready on third edge", 32'(rd_status), 32'd0);
    chk("R6 head word without request", 32'(rd_data), 32'h40);
    chk("R2 mode kept after reset", 32'(wr_status), 32'd0);

    // R7 fill to DEPTH+1
    for (int i = 1; i <= DEPTH; i++) do_write(DW'(8'h40 + i));
    settle();
    chk("R7 input-ready high when full", 32'(wr_status), 32'd1);
    chk("R9 head held", 32'(rd_data), 32'h40);
    do_write(8'hEE);
    settle();
    chk("R9 head still held", 32'(rd_data), 32'h40);
    do_read();
    chk("R9 next word after pop", 32'(rd_data), 32'h41);
    settle();
    chk("R7 input-ready low after read", 32'(wr_status), 32'd0);
    for (int i = 2; i <= DEPTH; i++) begin
      do_read();
      chk("R9 back-to-back pop", 32'(rd_data), 32'(8'h40 + i));
    end
    chk("R7 last word still valid", 32'(rd_status), 32'd0);
    do_read();
    chk("R7 overflow word dropped", 32'(rd_status), 32'd1);
    held = rd_data;
    do_read();
    chk("R8 fall read on empty ignored", 32'(rd_data), 32'(held));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule